// File: doc/BRIEF.md
# DRAM Rank Power-Down Controller

This block decides, for every rank of a DRAM channel, when the rank may drop into precharge power-down and when it must come back out. Each cycle it looks at three things per rank: whether the command queue holds anything for that rank, whether a refresh is owed to it, and the state of each of its banks as reported by the bank timing tracker. It drives back a registered powered-down flag, one-cycle pulses that tell the tracker to force all of the rank's banks into the power-down state or back to idle, and the earliest cycle at which an activate may follow a wake-up.

Residency and exit timing are handled with timestamps measured against a free-running cycle count supplied by the surrounding controller. Comparisons allow for wrap-around. Entering power-down stamps a minimum wake time. Leaving it stamps an activate lockout. The block also reports, every cycle, the background power mode of each rank so that an energy accountant elsewhere can pick the right current. A global enable input turns the feature off, which keeps every rank in standby.

Top module: `pd_rank_ctrl`

## Requirements
- R1: A rank enters power-down only in a cycle where `pd_en_i` is 1, the rank is not already powered down, its queue is empty, no refresh is waiting for it, and every one of its banks reports idle. Bank state codes are 3-bit fields, with bank b of rank r at bits [(r*N_BANKS+b)*3 +: 3]. The codes are: idle 0, row active 1, precharging 2, refreshing 3, power-down 4.
- R2: In an entry cycle, `force_pd_o` for that rank is 1 in that same cycle. `pd_o` rises at the following clock edge.
- R3: At entry, the earliest wake time becomes the current `now_i` plus T_CKE. A powered-down rank does not exit in any cycle before that time, even if a wake reason is present.
- R4: A powered-down rank exits in a cycle where it has a wake reason (queue not empty, refresh waiting, or `pd_en_i` low) and `now_i` has reached the wake time, using wrap-aware comparison. In that cycle `force_idle_o` is 1, and `pd_o` falls at the following edge. Otherwise the rank stays powered down.
- R5: In an exit cycle, `act_ts_o` for the rank loads `now_i` plus T_XP, visible after the edge. It holds its value in every other cycle.
- R6: `bg_mode_o` per rank (2 bits) is 0 (active) when any bank of the rank is row active or refreshing. Otherwise it is 2 (power-down) when `pd_o` is 1, and 1 (standby) when `pd_o` is 0.
- R7: While `pd_en_i` is 0, no rank enters power-down. Each rank's decision depends only on its own inputs.
- R8: During reset, `pd_o` is 0 and `act_ts_o` is 0 for every rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_en_i | input | 1 | Global power-down enable |
| now_i | input | TS_W | Current cycle count |
| cmdq_empty_i | input | N_RANKS | Per-rank queue empty flag |
| ref_wait_i | input | N_RANKS | Per-rank refresh waiting flag |
| bank_st_i | input | N_RANKS*N_BANKS*3 | Per-bank state codes |
| pd_o | output | N_RANKS | Registered powered-down flag |
| force_pd_o | output | N_RANKS | Entry pulse: force banks to power-down |
| force_idle_o | output | N_RANKS | Exit pulse: force banks to idle |
| act_ts_o | output | N_RANKS*TS_W | Earliest activate time after the last wake |
| bg_mode_o | output | N_RANKS*2 | Background power mode per rank |

## Verification
Two of the block's functions can fall in the same cycle. The first is the residency gate, which blocks an exit. The second is a wake request arriving while the rank is powered down. The sharpest case is a request that shows up on the very cycle after entry and is then held: the exit must land exactly T_CKE cycles after the entry cycle, not earlier.

The bench provokes this with a directed pass and also with a long biased sweep over both ranks. In the sweep, queue, refresh, enable and bank-state inputs change every cycle, and `now_i` wraps several times. A cycle-level reference model, written from the requirements, predicts the pulses, the flag, the timestamps and the background mode. The bench compares each of these against the outputs every cycle.

// File: rtl/pd_ctrl_pkg.sv
package pd_ctrl_pkg;
  localparam int BK_W = 3;

  typedef enum logic [BK_W-1:0] {
    BK_IDLE    = 3'd0,
    BK_ACTIVE  = 3'd1,
    BK_PRECHG  = 3'd2,
    BK_REFRESH = 3'd3,
    BK_PWRDN   = 3'd4
  } bank_st_e;

  typedef enum logic [1:0] {
    BG_ACTIVE  = 2'd0,
    BG_STANDBY = 2'd1,
    BG_PWRDN   = 2'd2
  } bg_mode_e;
endpackage

// File: rtl/pd_bank_scan.sv
module pd_bank_scan
  import pd_ctrl_pkg::*;
#(
  parameter int N_BANKS = 4
) (
  input  logic [N_BANKS*BK_W-1:0] st_i,
  output logic                    all_idle_o,
  output logic                    any_open_o
);
  logic [N_BANKS-1:0] idle_v, open_v;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic [BK_W-1:0] st;
    assign st        = st_i[b*BK_W +: BK_W];
    assign idle_v[b] = (st == BK_IDLE);
    assign open_v[b] = (st == BK_ACTIVE) || (st == BK_REFRESH);
  end

  assign all_idle_o = &idle_v;
  assign any_open_o = |open_v;
endmodule

// File: rtl/pd_wake_cmp.sv
module pd_wake_cmp #(
  parameter int TS_W = 16
) (
  input  logic [TS_W-1:0] now_i,
  input  logic [TS_W-1:0] ts_i,
  output logic            reached_o
);
  logic [TS_W-1:0] diff;
  // wrap-aware: now at or after ts within half the range
  assign diff      = now_i - ts_i;
  assign reached_o = ~diff[TS_W-1];
endmodule

// File: rtl/pd_rank_fsm.sv
module pd_rank_fsm
  import pd_ctrl_pkg::*;
#(
  parameter int TS_W  = 16,
  parameter int T_CKE = 3,
  parameter int T_XP  = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [TS_W-1:0] now_i,
  input  logic            empty_i,
  input  logic            ref_i,
  input  logic            all_idle_i,
  input  logic            any_open_i,
  output logic            enter_o,
  output logic            exit_o,
  output logic            pd_o,
  output logic [TS_W-1:0] act_ts_o,
  output bg_mode_e        bg_o
);
  localparam logic [TS_W-1:0] CKE_D = TS_W'(T_CKE);
  localparam logic [TS_W-1:0] XP_D  = TS_W'(T_XP);

  logic            pd_q;
  logic [TS_W-1:0] wake_ts_q, act_ts_q;
  logic            reached, wake_req;

  pd_wake_cmp #(.TS_W(TS_W)) u_cmp (
    .now_i     (now_i),
    .ts_i      (wake_ts_q),
    .reached_o (reached)
  );

  assign wake_req = !empty_i || ref_i || !en_i;
  assign enter_o  = en_i && !pd_q && empty_i && !ref_i && all_idle_i;
  assign exit_o   = pd_q && wake_req && reached;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_q      <= 1'b0;
      wake_ts_q <= '0;
      act_ts_q  <= '0;
    end else if (enter_o) begin
      pd_q      <= 1'b1;
      wake_ts_q <= now_i + CKE_D;
    end else if (exit_o) begin
      pd_q      <= 1'b0;
      act_ts_q  <= now_i + XP_D;
    end
  end

  always_comb begin
    if (any_open_i)  bg_o = BG_ACTIVE;
    else if (pd_q)   bg_o = BG_PWRDN;
    else             bg_o = BG_STANDBY;
  end

  assign pd_o     = pd_q;
  assign act_ts_o = act_ts_q;

  // R1
  entry_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_q) |-> $past(en_i && empty_i && !ref_i && all_idle_i));
  // R3
  exit_resid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pd_q) |-> $past(reached && wake_req));
  // R5
  act_ts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pd_q) |-> (act_ts_q == $past(now_i) + XP_D));
  // R7
  no_entry_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_q) |-> $past(en_i));
  // R4
  pd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enter_o && !exit_o) |=> $stable(pd_q));
endmodule

// File: rtl/pd_rank_ctrl.sv
module pd_rank_ctrl
  import pd_ctrl_pkg::*;
#(
  parameter int N_RANKS = 2,
  parameter int N_BANKS = 4,
  parameter int TS_W    = 16,
  parameter int T_CKE   = 3,
  parameter int T_XP    = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          pd_en_i,
  input  logic [TS_W-1:0]               now_i,
  input  logic [N_RANKS-1:0]            cmdq_empty_i,
  input  logic [N_RANKS-1:0]            ref_wait_i,
  input  logic [N_RANKS*N_BANKS*3-1:0]  bank_st_i,
  output logic [N_RANKS-1:0]            pd_o,
  output logic [N_RANKS-1:0]            force_pd_o,
  output logic [N_RANKS-1:0]            force_idle_o,
  output logic [N_RANKS*TS_W-1:0]       act_ts_o,
  output logic [N_RANKS*2-1:0]          bg_mode_o
);
  localparam int RANK_ST_W = N_BANKS * BK_W;

  for (genvar r = 0; r < N_RANKS; r++) begin : g_rank
    logic     all_idle, any_open;
    bg_mode_e bg;

    pd_bank_scan #(.N_BANKS(N_BANKS)) u_scan (
      .st_i       (bank_st_i[r*RANK_ST_W +: RANK_ST_W]),
      .all_idle_o (all_idle),
      .any_open_o (any_open)
    );

    pd_rank_fsm #(.TS_W(TS_W), .T_CKE(T_CKE), .T_XP(T_XP)) u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (pd_en_i),
      .now_i      (now_i),
      .empty_i    (cmdq_empty_i[r]),
      .ref_i      (ref_wait_i[r]),
      .all_idle_i (all_idle),
      .any_open_i (any_open),
      .enter_o    (force_pd_o[r]),
      .exit_o     (force_idle_o[r]),
      .pd_o       (pd_o[r]),
      .act_ts_o   (act_ts_o[r*TS_W +: TS_W]),
      .bg_o       (bg)
    );

    assign bg_mode_o[r*2 +: 2] = bg;

    // R6
    bg_pd_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bg == BG_PWRDN) |-> pd_o[r]);
    // R2
    pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({force_pd_o[r], force_idle_o[r]}));
  end
endmodule

// File: tb/sim_pd_rank_ctrl.sv
module sim_pd_rank_ctrl;
  localparam int NR = 2, NB = 2, TW = 8, TCKE = 3, TXP = 2;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [TW-1:0] now = '0;
  logic [NR-1:0] empty = '1, refw = '0;
  logic [NR*NB*3-1:0] bst = '0;
  logic [NR-1:0] pd, fpd, fidle;
  logic [NR*TW-1:0] act;
  logic [NR*2-1:0] bg;

  int n_chk = 0, n_bad = 0;
  logic [NR-1:0] pd_m = '0;
  logic [TW-1:0] wake_m [NR];
  logic [TW-1:0] act_m [NR];
  string tag_pd = "R1", tag_ex = "R4";

  always #5 clk = ~clk;

  pd_rank_ctrl #(.N_RANKS(NR), .N_BANKS(NB), .TS_W(TW), .T_CKE(TCKE), .T_XP(TXP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pd_en_i(en), .now_i(now),
    .cmdq_empty_i(empty), .ref_wait_i(refw), .bank_st_i(bst),
    .pd_o(pd), .force_pd_o(fpd), .force_idle_o(fidle),
    .act_ts_o(act), .bg_mode_o(bg));

  task automatic chk(string tag, string what, int act_v, int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act_v, exp_v);
    end
  endtask

  function automatic bit reached(logic [TW-1:0] n, logic [TW-1:0] w);
    logic [TW-1:0] d;
    d = n - w;
    return d < (1 << (TW-1));
  endfunction

  // one cycle: inputs already driven after negedge; compare, update model, advance
  task automatic step(output logic [NR-1:0] ent, output logic [NR-1:0] ext);
    #1;
    for (int r = 0; r < NR; r++) begin
      bit idle = 1, open = 0, e, x;
      int bg_e;
      for (int b = 0; b < NB; b++) begin
        logic [2:0] s;
        s = bst[(r*NB+b)*3 +: 3];
        if (s != 3'd0) idle = 0;
        if (s == 3'd1 || s == 3'd3) open = 1;
      end
      e = en && !pd_m[r] && empty[r] && !refw[r] && idle;
      x = pd_m[r] && (!empty[r] || refw[r] || !en) && reached(now, wake_m[r]);
      bg_e = open ? 0 : (pd_m[r] ? 2 : 1);
      chk(tag_pd, "force_pd", int'(fpd[r]), int'(e));
      chk(tag_ex, "force_idle", int'(fidle[r]), int'(x));
      chk("R6", "bg_mode", int'(bg[r*2 +: 2]), bg_e);
      chk("R2", "pd_o", int'(pd[r]), int'(pd_m[r]));
      chk("R5", "act_ts", int'(act[r*TW +: TW]), int'(act_m[r]));
      ent[r] = e; ext[r] = x;
      if (e) begin pd_m[r] = 1'b1; wake_m[r] = now + TW'(TCKE); end
      else if (x) begin pd_m[r] = 1'b0; act_m[r] = now + TW'(TXP); end
    end
    @(posedge clk); @(negedge clk);
    now = now + 1'b1;
  endtask

  initial begin
    #300000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [NR-1:0] ent, ext;
    int t_ent;
    for (int r = 0; r < NR; r++) begin wake_m[r] = '0; act_m[r] = '0; end
    repeat (3) @(negedge clk);
    // R8 reset values
    for (int r = 0; r < NR; r++) begin
      chk("R8", "pd_o in reset", int'(pd[r]), 0);
      chk("R8", "act_ts in reset", int'(act[r*TW +: TW]), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R7: disabled, everything idle and empty -> never enters
    tag_pd = "R7";
    for (int i = 0; i < 20; i++) begin
      empty = '1; refw = '0; bst = '0; step(ent, ext);
    end

    // R3 directed: enter, wake request at once, exit exactly TCKE later
    tag_pd = "R1"; tag_ex = "R3";
    en = 1'b1; empty = '1;
    step(ent, ext);
    chk("R1", "entry in idle cycle", int'(ent[0]), 1);
    t_ent = 0;
    empty[0] = 1'b0; bst[2:0] = 3'd4; bst[5:3] = 3'd4;
    for (int i = 1; i <= TCKE + 2; i++) begin
      step(ent, ext);
      if (ext[0]) begin
        if (t_ent == 0) t_ent = i;
      end
    end
    chk("R3", "cycles from entry to exit", t_ent, TCKE);

    // near-exhaustive biased sweep, now wraps many times
    tag_ex = "R4";
    for (int i = 0; i < 3000; i++) begin
      en = (i % 500) < 450;
      tag_pd = en ? "R1" : "R7";
      for (int r = 0; r < NR; r++) begin
        empty[r] = ($urandom % 4) != 0;
        refw[r]  = ($urandom % 8) == 0;
        for (int b = 0; b < NB; b++)
          bst[(r*NB+b)*3 +: 3] = (($urandom % 4) != 0) ? 3'd0 : 3'(1 + $urandom % 4);
      end
      step(ent, ext);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule